// File: doc/BRIEF.md
# Periodic Compare Interrupt Unit

This block is an 8-bit register-mapped timer and interrupt collector. It has three parts. An 8-bit counter advances once for each 32.768 kHz tick enable, so one count lasts about 30.5 us. A compare register is loaded by software. The tick that moves the counter onto the compare value raises a periodic event.

The periodic event and six single-cycle event pulses from an external serial transceiver are held in one sticky status byte. The transceiver pulses report transmit empty, transmit complete, receive full, overrun, noise and framing error. A read of the status byte returns its contents and clears it. The IRQ output is high while any status bit is set, so reading the status byte lowers IRQ.

Software sets up a periodic tick by reading the compare register, adding 205 (about 6.25 ms) and writing the sum back. The sum wraps modulo 256.

Top module: `periodic_compare_irq`

## Requirements
- R1: After a synchronous reset, the counter reads 0x00, the compare register reads 0xFF, the status byte reads 0x00 and irq is low.
- R2: The counter at offset 5 rises by one in each cycle where tick_en is high and wraps from 0xFF to 0x00. It holds its value in all other cycles. Read data appears on rdata in the cycle after the read strobe.
- R3: The compare register at offset 6 is readable and writable. It keeps a written value unchanged, so a read, an add of 0xCD modulo 256 and a write back all work as software expects.
- R4: Status bit 0 is set when a tick moves the counter onto the compare value. The match does not set the bit again while the counter stays at that value between ticks.
- R5: The status byte at offset 8 has this layout. Bit 7 is transmit empty, bit 6 is transmit complete and bit 5 is receive full. Bit 4 always reads 0. Bit 3 is overrun, bit 2 is noise and bit 1 is framing error, so the receive error flags are the mask 0x0E. Bit 0 is the periodic match.
- R6: A status bit stays set from its event until the next status read. That read returns the held byte and clears it.
- R7: An event that arrives in the same cycle as a clearing status read is not part of that read's data. It is held for the next read.
- R8: irq is a register that is high exactly when any status bit is set. A status read with no new event lowers irq in the following cycle.
- R9: Writes to offset 5 (counter) and to offset 8 (status) are ignored.
- R10: A read of any offset other than 5, 6 or 8 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | 32.768 kHz count enable, one cycle wide |
| addr | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ev_tx_empty | input | 1 | Transmit empty pulse |
| ev_tx_done | input | 1 | Transmit complete pulse |
| ev_rx_full | input | 1 | Receive full pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_noise | input | 1 | Receive noise pulse |
| ev_framing | input | 1 | Receive framing error pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two things can happen on the same edge: a status read clears the byte, and a new event (a serial pulse or a compare match) sets a bit. The bench forces this case on purpose. It drives a read together with a serial pulse, and it times a read onto the tick that reaches the compare value. It then checks three things: the first read lacks the new bit, irq stays high, and the next read shows the new bit. Random runs with free ticks, events, reads and writes then compare each read and each irq cycle against a bench model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] OFS_COUNT  = 4'd5;
  localparam logic [AW-1:0] OFS_CMP    = 4'd6;
  localparam logic [AW-1:0] OFS_STATUS = 4'd8;
  localparam logic [DW-1:0] CMP_RESET  = 8'hFF;
  // status bit positions
  localparam int SB_MATCH = 0;
  localparam int SB_FRAME = 1;
  localparam int SB_NOISE = 2;
  localparam int SB_OVR   = 3;
  localparam int SB_SPARE = 4;
  localparam int SB_RXF   = 5;
  localparam int SB_TXC   = 6;
  localparam int SB_TXE   = 7;
  localparam logic [DW-1:0] STATUS_LIVE = 8'hEF;
endpackage

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic         match
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] count_q;
  logic [W-1:0] count_inc;

  assign count_inc = count_q + ONE;
  assign count     = count_q;
  // fires only on the tick that lands on the compare value
  assign match     = tick_en && (count_inc == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else if (tick_en) count_q <= count_inc;
  end

  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count_q));
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> count_q == $past(count_q) + ONE);
  p_match_once_r4: assert property (@(posedge clk) disable iff (rst)
    (match && !tick_en) == 1'b0);
endmodule

// File: rtl/pcu_compare.sv
module pcu_compare #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cmp_val
);
  always_ff @(posedge clk) begin
    if (rst) cmp_val <= RST_VAL;
    else if (load) cmp_val <= load_val;
  end

  p_cmp_keep_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cmp_val));
  p_cmp_load_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> cmp_val == $past(load_val));
endmodule

// File: rtl/pcu_status.sv
module pcu_status #(
  parameter int W = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_vec,
  input  logic         rd_clr,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] flags_d;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (LIVE[i]) begin : g_live
        assign flags_d[i] = (flags[i] & ~rd_clr) | ev_vec[i];
      end else begin : g_dead
        assign flags_d[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= |flags_d;
    end
  end

  p_irq_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags));
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && ((ev_vec & LIVE) == '0)) |=> (flags == '0 && !irq));
  p_keep_new_r7: assert property (@(posedge clk) disable iff (rst)
    ((ev_vec & LIVE) != '0) |=> ((flags & $past(ev_vec & LIVE)) == $past(ev_vec & LIVE)));
  p_spare_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (flags & ~LIVE) == '0);
endmodule

// File: rtl/periodic_compare_irq.sv
module periodic_compare_irq
  import pcu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ev_tx_empty,
  input  logic          ev_tx_done,
  input  logic          ev_rx_full,
  input  logic          ev_overrun,
  input  logic          ev_noise,
  input  logic          ev_framing,
  output logic          irq
);
  logic [DW-1:0] count, cmp_val, flags, ev_vec;
  logic          match, cmp_load, stat_rd;

  assign cmp_load = wr_en && (addr == OFS_CMP);
  assign stat_rd  = rd_en && (addr == OFS_STATUS);

  always_comb begin
    ev_vec           = '0;
    ev_vec[SB_MATCH] = match;
    ev_vec[SB_FRAME] = ev_framing;
    ev_vec[SB_NOISE] = ev_noise;
    ev_vec[SB_OVR]   = ev_overrun;
    ev_vec[SB_RXF]   = ev_rx_full;
    ev_vec[SB_TXC]   = ev_tx_done;
    ev_vec[SB_TXE]   = ev_tx_empty;
  end

  pcu_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cmp_val(cmp_val),
    .count(count), .match(match)
  );

  pcu_compare #(.W(DW), .RST_VAL(CMP_RESET)) u_cmp (
    .clk(clk), .rst(rst), .load(cmp_load), .load_val(wdata), .cmp_val(cmp_val)
  );

  pcu_status #(.W(DW), .LIVE(STATUS_LIVE)) u_stat (
    .clk(clk), .rst(rst), .ev_vec(ev_vec), .rd_clr(stat_rd),
    .flags(flags), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      unique case (addr)
        OFS_COUNT:  rdata <= count;
        OFS_CMP:    rdata <= cmp_val;
        OFS_STATUS: rdata <= flags;
        default:    rdata <= '0;
      endcase
    end
  end

  p_ro_count_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_COUNT && !tick_en) |=> $stable(count));
  p_read_other_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != OFS_COUNT && addr != OFS_CMP && addr != OFS_STATUS) |=> rdata == '0);
endmodule

// File: tb/sim_periodic_compare_irq.sv
module sim_periodic_compare_irq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic ev_tx_empty = 0, ev_tx_done = 0, ev_rx_full = 0, ev_overrun = 0, ev_noise = 0, ev_framing = 0;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_cnt, m_cmp, m_flags, m_rd;
  logic       m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_compare_irq u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .ev_tx_empty(ev_tx_empty), .ev_tx_done(ev_tx_done), .ev_rx_full(ev_rx_full),
    .ev_overrun(ev_overrun), .ev_noise(ev_noise), .ev_framing(ev_framing), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ev_bits(logic [5:0] ev, logic match);
    // ev = {tx_empty, tx_done, rx_full, overrun, noise, framing}
    return {ev[5], ev[4], ev[3], 1'b0, ev[2], ev[1], ev[0], match};
  endfunction

  function automatic string rd_req(logic [3:0] a);
    if (a == 4'd5) return "R2 counter read";
    if (a == 4'd6) return "R3 compare read";
    if (a == 4'd8) return "R6 status read";
    return "R10 unmapped read";
  endfunction

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(logic t, logic [5:0] ev, logic rd, logic wr, logic [3:0] a, logic [7:0] wd);
    logic match;
    tick_en = t; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    {ev_tx_empty, ev_tx_done, ev_rx_full, ev_overrun, ev_noise, ev_framing} = ev;
    @(posedge clk);
    match = t && ((m_cnt + 8'd1) == m_cmp);
    if (rd) begin
      if (a == 4'd5) m_rd = m_cnt;
      else if (a == 4'd6) m_rd = m_cmp;
      else if (a == 4'd8) m_rd = m_flags;
      else m_rd = 8'h00;
    end
    m_flags = ((rd && a == 4'd8) ? 8'h00 : m_flags) | ev_bits(ev, match);
    if (t) m_cnt = m_cnt + 8'd1;
    if (wr && a == 4'd6) m_cmp = wd;
    m_irq = (m_flags != 8'h00);
    @(negedge clk);
    tick_en = 0; rd_en = 0; wr_en = 0;
    {ev_tx_empty, ev_tx_done, ev_rx_full, ev_overrun, ev_noise, ev_framing} = '0;
    if (rd) check(rd_req(a), rdata, m_rd);
    check("R8 irq", {7'd0, irq}, {7'd0, m_irq});
  endtask

  task automatic rd(logic [3:0] a);
    step(0, 6'd0, 1, 0, a, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    m_cnt = 0; m_cmp = 8'hFF; m_flags = 0; m_irq = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(4'd5); check("R1 counter after reset", rdata, 8'h00);
    rd(4'd6); check("R1 compare after reset", rdata, 8'hFF);
    rd(4'd8); check("R1 status after reset", rdata, 8'h00);

    // R4 match on tick reaching compare, not again while holding
    step(0, 6'd0, 0, 1, 4'd6, 8'h03);
    step(1, 6'd0, 0, 0, 4'd0, 8'h00);
    step(1, 6'd0, 0, 0, 4'd0, 8'h00);
    check("R4 no early match irq", {7'd0, irq}, 8'h00);
    step(1, 6'd0, 0, 0, 4'd0, 8'h00);
    check("R4 match raises irq", {7'd0, irq}, 8'h01);
    rd(4'd8); check("R4 match bit0", rdata, 8'h01);
    repeat (5) step(0, 6'd0, 0, 0, 4'd0, 8'h00);
    check("R4 no refire while holding", {7'd0, irq}, 8'h00);
    rd(4'd8); check("R4 status stays clear", rdata, 8'h00);

    // R5 each serial event lands on its own bit
    for (int i = 0; i < 6; i++) begin
      logic [7:0] exp;
      step(0, 6'(1 << i), 0, 0, 4'd0, 8'h00);
      rd(4'd8);
      exp = ev_bits(6'(1 << i), 1'b0);
      check("R5 status bit layout", rdata, exp);
    end
    step(0, 6'b000111, 0, 0, 4'd0, 8'h00);
    rd(4'd8); check("R5 receive error mask", rdata & 8'h0E, 8'h0E);

    // R7 event in same cycle as clearing read is kept
    step(0, 6'b100000, 0, 0, 4'd0, 8'h00);
    step(0, 6'b000001, 1, 0, 4'd8, 8'h00);
    check("R7 read excludes same-cycle event", rdata, 8'h80);
    check("R7 irq stays high", {7'd0, irq}, 8'h01);
    rd(4'd8); check("R7 event kept for next read", rdata, 8'h02);
    // R7 compare match coinciding with read
    step(0, 6'd0, 0, 1, 4'd6, m_cnt + 8'd1);
    step(1, 6'd0, 1, 0, 4'd8, 8'h00);
    check("R7 match during read not in data", rdata, 8'h00);
    rd(4'd8); check("R7 match kept", rdata, 8'h01);

    // R9 writes to read-only offsets ignored
    step(0, 6'b010000, 0, 0, 4'd0, 8'h00);
    step(0, 6'd0, 0, 1, 4'd5, 8'hA5);
    rd(4'd5); check("R9 counter not written", rdata, m_cnt);
    step(0, 6'd0, 0, 1, 4'd8, 8'h00);
    rd(4'd8); check("R9 status not written", rdata, 8'h40);

    // R3 read, add 0xCD, write back wraps modulo 256
    step(0, 6'd0, 0, 1, 4'd6, 8'h50);
    rd(4'd6);
    step(0, 6'd0, 0, 1, 4'd6, rdata + 8'hCD);
    rd(4'd6); check("R3 add 0xCD wraps", rdata, 8'h1D);

    // R2 wrap through 0xFF
    for (int i = 0; i < 300; i++) step(1, 6'd0, 0, 0, 4'd0, 8'h00);
    rd(4'd5); check("R2 counter after wrap", rdata, m_cnt);
    rd(4'd8);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      int op;
      logic [5:0] ev;
      op = $urandom_range(0, 9);
      a = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) :
          ((op[0]) ? 4'd8 : (op[1] ? 4'd6 : 4'd5));
      ev = ($urandom_range(0, 5) == 0) ? 6'($urandom_range(0, 63)) : 6'd0;
      step($urandom_range(0, 2) == 0, ev, op < 4, op == 9, a, 8'($urandom_range(0, 255)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule